// File: doc/BRIEF.md
# Keypad Wake-Up Interrupt Controller

This block watches an 8-bit input port that a keypad drives, and turns any key press on a selected set of pins into one shared interrupt. Each pin has its own enable bit in a mask register. When any enabled pin is held low, a sticky flag is set. That flag drives the interrupt request when the global interrupt-enable input is high. Software finds out which key was pressed by reading the port itself. It clears the flag by writing to the status address.

A separate wake request is the OR, across all pins, of "enabled and low". This path is purely combinational, so a power controller can use it to restart a processor whose clock is stopped. The clocked flag path takes the port through a two-flop synchronizer. A clear that arrives while an enabled pin is still low does not take effect.

Top module: `kbw_ctrl`

## Requirements
- R1: The enable mask is at register address 0. Writing it with `reg_we_i` stores `reg_wdata_i`, and reading address 0 returns it on `reg_rdata_o`. Bit n enables port pin n.
- R2: When any enabled pin is low, the flag is set. The flag reads 1 at the third rising clock edge after the pin goes low, and not before (two synchronizer stages, then the flag register).
- R3: Once set, the flag stays set until software writes address 1 with data bit 0 = 1. Writes to address 1 with bit 0 = 0 leave the flag unchanged.
- R4: `irq_o` is high exactly when the flag is set and `irq_en_i` is high.
- R5: A pin whose mask bit is 0 has no effect on the flag or on `wake_o`, whatever its level.
- R6: `wake_o` is high whenever any enabled pin is low, with no clock edge needed. This holds even while the clock is stopped.
- R7: A clear written in a cycle where the synchronized set condition is still true leaves the flag set.
- R8: Reading address 1 returns the flag in bit 0 and zeros in bits 7..1.
- R9: After reset the mask is 00h, the flag is 0, and `irq_o` and `wake_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_i | input | 8 | Keypad port pins, low means pressed |
| irq_en_i | input | 1 | Global keypad interrupt enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register address: 0 = mask, 1 = status |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the selected address |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Combinational wake request |

## Verification
The assertions check on every cycle the following:
- the flag stays set unless a clear is accepted;
- the flag rises only after a synchronized set request;
- set wins over clear;
- mask writes land;
- a zero mask never produces a wake.

Only the bench scenarios can show the exact three-edge latency of the flag, that the wake path responds while the clock is stopped, the read-back encoding, and that disabled pins held low leave both outputs quiet.

// File: rtl/kbw_pkg.sv
package kbw_pkg;
  parameter int unsigned N_PINS   = 8;
  parameter int unsigned SYNC_LEN = 2;
  localparam logic ADDR_MASK = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
  localparam int unsigned FLAG_BIT = 0;
endpackage

// File: rtl/kbw_sync.sv
module kbw_sync #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [DEPTH];

  // idle level is high (keys released)
  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '1;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/kbw_detect.sv
module kbw_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] port_raw_i,
  input  logic [WIDTH-1:0] port_sync_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic             set_req_o,
  output logic             wake_o
);
  logic [WIDTH-1:0] hit_raw, hit_sync;

  generate
    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
      assign hit_raw[p]  = mask_i[p] & ~port_raw_i[p];
      assign hit_sync[p] = mask_i[p] & ~port_sync_i[p];
    end
  endgenerate

  // wake bypasses the clock so it works from power-down
  assign wake_o    = |hit_raw;
  assign set_req_o = |hit_sync;

  always_comb begin
    a_r5_zero_mask_quiet: assert (!(mask_i == '0 && (wake_o || set_req_o)));
  end
endmodule

// File: rtl/kbw_regs.sv
module kbw_regs
  import kbw_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             set_req_i,
  output logic [WIDTH-1:0] mask_o,
  output logic             flag_o,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mask_q;
  logic             flag_q;
  logic             clr_req;

  assign clr_req = we_i && (addr_i == ADDR_STAT) && wdata_i[FLAG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (we_i && addr_i == ADDR_MASK) mask_q <= wdata_i;
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (set_req_i) flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_MASK) rdata_o = mask_q;
    else rdata_o[FLAG_BIT] = flag_q;
  end

  assign mask_o = mask_q;
  assign flag_o = flag_q;

  a_r3_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_req |=> flag_q);
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_req_i && clr_req |=> flag_q);
  a_r2_rise_needs_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_q && !set_req_i |=> !flag_q);
  a_r1_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == ADDR_MASK |=> mask_q == $past(wdata_i));
endmodule

// File: rtl/kbw_ctrl.sv
module kbw_ctrl
  import kbw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] port_i,
  input  logic              irq_en_i,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [N_PINS-1:0] reg_wdata_i,
  output logic [N_PINS-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic [N_PINS-1:0] port_sync, mask;
  logic              set_req, flag;

  kbw_sync #(.WIDTH(N_PINS), .DEPTH(SYNC_LEN)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(port_i), .q_o(port_sync)
  );

  kbw_detect #(.WIDTH(N_PINS)) u_detect (
    .port_raw_i(port_i), .port_sync_i(port_sync), .mask_i(mask),
    .set_req_o(set_req), .wake_o(wake_o)
  );

  kbw_regs #(.WIDTH(N_PINS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .set_req_i(set_req), .mask_o(mask),
    .flag_o(flag), .rdata_o(reg_rdata_o)
  );

  assign irq_o = flag & irq_en_i;

  a_r4_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en_i);
endmodule

// File: tb/kbw_ctrl_test.sv
`timescale 1ns/1ps
module kbw_ctrl_test;
  logic       clk = 1'b0;
  logic       run = 1'b1;
  logic       rst_ni = 1'b0;
  logic [7:0] port = 8'hFF;
  logic       irq_en = 1'b0;
  logic       we = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, wake;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = run ? ~clk : clk;

  kbw_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .port_i(port), .irq_en_i(irq_en),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic a, logic [7:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R9 mask", 1'b0, 8'h00);
    rd_chk("R9 flag", 1'b1, 8'h00);
    chk("R9 irq", {7'd0, irq}, 8'h00);
    chk("R9 wake", {7'd0, wake}, 8'h00);
  endtask

  task automatic t_mask_rw;
    wr(1'b0, 8'hA5);
    rd_chk("R1 mask A5", 1'b0, 8'hA5);
    wr(1'b0, 8'h3C);
    rd_chk("R1 mask 3C", 1'b0, 8'h3C);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_disabled;
    wr(1'b0, 8'h0F);
    port = 8'h00 | 8'h0F;  // upper disabled pins low
    edges(5);
    rd_chk("R5 flag stays", 1'b1, 8'h00);
    chk("R5 wake quiet", {7'd0, wake}, 8'h00);
    port = 8'hFF;
    edges(3);
  endtask

  task automatic t_flag_latency;
    wr(1'b0, 8'h01);
    port = 8'hFE;
    #1 chk("R6 wake immediate", {7'd0, wake}, 8'h01);
    edges(2);
    rd_chk("R2 not yet set", 1'b1, 8'h00);
    edges(1);
    rd_chk("R2 set at edge 3", 1'b1, 8'h01);
  endtask

  task automatic t_sticky_irq;
    port = 8'hFF;
    edges(4);
    rd_chk("R3 sticky after release", 1'b1, 8'h01);
    irq_en = 1'b0; #1;
    chk("R4 irq masked", {7'd0, irq}, 8'h00);
    irq_en = 1'b1; #1;
    chk("R4 irq asserted", {7'd0, irq}, 8'h01);
    wr(1'b1, 8'hFE);
    rd_chk("R3 bit0=0 no clear", 1'b1, 8'h01);
    wr(1'b1, 8'h01);
    rd_chk("R3 cleared", 1'b1, 8'h00);
    chk("R4 irq drops", {7'd0, irq}, 8'h00);
    rd_chk("R8 status upper zero", 1'b1, 8'h00);
  endtask

  task automatic t_set_wins;
    wr(1'b0, 8'h80);
    port = 8'h7F;
    edges(3);
    rd_chk("R8 status reads 01", 1'b1, 8'h01);
    wr(1'b1, 8'h01);
    rd_chk("R7 set beats clear", 1'b1, 8'h01);
    port = 8'hFF;
    edges(2);
    wr(1'b1, 8'h01);
    rd_chk("R7 clear after release", 1'b1, 8'h00);
  endtask

  task automatic t_wake_stopped;
    wr(1'b0, 8'h10);
    @(negedge clk); run = 1'b0;
    #20 port = 8'hEF;
    #1 chk("R6 wake w/o clock", {7'd0, wake}, 8'h01);
    port = 8'hF7;
    #1 chk("R5 disabled pin no wake", {7'd0, wake}, 8'h00);
    port = 8'hFF;
    #20 run = 1'b1;
    edges(3);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #23 rst_ni = 1'b1;
    @(negedge clk);
    t_reset;
    t_mask_rw;
    t_disabled;
    t_flag_latency;
    t_sticky_irq;
    t_set_wins;
    t_wake_stopped;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule